// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This unit sits between the input stage of a general-purpose I/O port and the interrupt controller above it. It receives the line values after polarity adjustment, so a line that is active low has already been inverted. It turns them into grouped interrupt requests. Each line can raise an interrupt in two ways. Edge events latch into a sticky cause register until software acknowledges them. Level requests use the adjusted input value itself, so they fall away as soon as the line drops.

Software reaches the cause register and the mask registers through a simple register port. Writes are strobed, and reads are combinational from the address. An edge-mask and a level-mask register select which causes count for a processor. The unit ORs the pending bits of each group of lines into one registered summary output per group. With the dual-processor option a second mask pair exists. That pair drives a second summary vector, which is independent of the first.

Top module: `gpio_irq_agg`

## Requirements
- R1: Register map: the edge cause is at 0x14, the processor-0 edge mask at 0x18 and the processor-0 level mask at 0x1C. A write to a mask replaces all of its bits. `reg_rdata` returns the addressed register in the same cycle. An unmapped address reads 0.
- R2: When a line is sampled low on one clock edge and high on the next, its bit in the edge cause is set at that second edge and can be read right after it.
- R3: An edge-cause bit stays set after its line falls, and it stays set until software clears it.
- R4: A write to 0x14 clears every cause bit written as 0 and leaves every bit written as 1 unchanged.
- R5: If a rising edge and a clearing write hit the same cause bit on the same edge, the bit ends up set.
- R6: A line whose level-mask bit is 1 is pending while its input is high and no longer pending once it is low, whatever its cause bit holds.
- R7: A line is pending when (input AND level mask) OR (cause AND edge mask) is 1. A latched cause whose edge-mask bit is 0 raises no summary bit, and it does raise one once the mask is set.
- R8: Summary bit g is the OR of the pending bits of lines 8g to 8g+7. It is registered, so it reflects the pending state one clock edge later.
- R9: With `DUAL_CPU`=1, processor 1 has an edge mask at 0x30 and a level mask at 0x34, both readable. Those masks drive `irq_sum1` without affecting `irq_sum0`, and the processor-0 masks do not affect `irq_sum1`.
- R10: After reset the cause register and all mask registers read 0 and both summary vectors are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | LINES | Polarity-adjusted line values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | LINES | Register write data |
| reg_rdata | output | LINES | Register read data for `reg_addr` |
| irq_sum0 | output | LINES/GROUP | Grouped summary interrupts, processor 0 |
| irq_sum1 | output | LINES/GROUP | Grouped summary interrupts, processor 1 (0 when single) |

## Verification
A corrupted cause bit appears on `reg_rdata` as soon as 0x14 is addressed. It reaches the summary output one edge after the flop goes wrong, but only if its edge mask is set. A missed or spurious edge therefore shows up within two clock edges of the line change. A wrong mask bit stays hidden until a matching cause or input arrives. For that reason the tests arm each mask before driving its line, and they read every mask back. A summary flop that picks the wrong group, or the wrong processor's masks, shows up one edge after the pending change. Each test therefore checks that exact cycle as well as the cycle before it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFF_CAUSE = 8'h14;

  function automatic logic [7:0] emask_off(input int cpu);
    return (cpu == 0) ? 8'h18 : 8'h30;
  endfunction

  function automatic logic [7:0] lmask_off(input int cpu);
    return (cpu == 0) ? 8'h1C : 8'h34;
  endfunction
endpackage

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic             clr_en,
  input  logic [LINES-1:0] clr_keep,
  output logic [LINES-1:0] cause_q
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] cause_d;
  logic             cause_en;

  // a new edge is ORed in after the clear, so the set wins
  always_comb begin
    rise     = line_in & ~prev_q;
    cause_d  = clr_en ? (cause_q & clr_keep) : cause_q;
    cause_d  = cause_d | rise;
    cause_en = clr_en | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q <= line_in;
      if (cause_en) cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_edge,
  input  logic             wr_level,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] edge_mask,
  output logic [LINES-1:0] level_mask
);
  logic [LINES-1:0] edge_d, level_d;

  always_comb begin
    edge_d  = wr_edge  ? wdata : edge_mask;
    level_d = wr_level ? wdata : level_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_mask  <= '0;
      level_mask <= '0;
    end else begin
      if (wr_edge)  edge_mask  <= edge_d;
      if (wr_level) level_mask <= level_d;
    end
  end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int LINES = 32,
  parameter int GROUP = 8,
  localparam int NGRP = LINES / GROUP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] cause,
  input  logic [LINES-1:0] edge_mask,
  input  logic [LINES-1:0] level_mask,
  output logic [NGRP-1:0]  sum_q
);
  logic [LINES-1:0] pending;
  logic [NGRP-1:0]  sum_d;

  always_comb pending = (line_in & level_mask) | (cause & edge_mask);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign sum_d[g] = |pending[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int LINES    = 32,
  parameter int GROUP    = 8,
  parameter int ADDR_W   = 8,
  parameter bit DUAL_CPU = 1'b1,
  localparam int NGRP = LINES / GROUP,
  localparam int NCPU = DUAL_CPU ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic [NGRP-1:0]   irq_sum0,
  output logic [NGRP-1:0]   irq_sum1
);
  logic                       wr_cause;
  logic [LINES-1:0]           cause;
  logic [1:0][LINES-1:0]      emask;
  logic [1:0][LINES-1:0]      lmask;
  logic [1:0][NGRP-1:0]       sum;

  assign wr_cause = reg_wr && (reg_addr == ADDR_W'(OFF_CAUSE));

  gpio_edge_cause #(.LINES(LINES)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .clr_en   (wr_cause),
    .clr_keep (reg_wdata),
    .cause_q  (cause)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cpu
    if (c < NCPU) begin : g_on
      logic wr_e, wr_l;
      assign wr_e = reg_wr && (reg_addr == ADDR_W'(emask_off(c)));
      assign wr_l = reg_wr && (reg_addr == ADDR_W'(lmask_off(c)));

      gpio_mask_bank #(.LINES(LINES)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_edge    (wr_e),
        .wr_level   (wr_l),
        .wdata      (reg_wdata),
        .edge_mask  (emask[c]),
        .level_mask (lmask[c])
      );

      gpio_irq_summary #(.LINES(LINES), .GROUP(GROUP)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .cause      (cause),
        .edge_mask  (emask[c]),
        .level_mask (lmask[c]),
        .sum_q      (sum[c])
      );
    end else begin : g_off
      assign emask[c] = '0;
      assign lmask[c] = '0;
      assign sum[c]   = '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_CAUSE))         reg_rdata = cause;
    else if (reg_addr == ADDR_W'(emask_off(0))) reg_rdata = emask[0];
    else if (reg_addr == ADDR_W'(lmask_off(0))) reg_rdata = lmask[0];
    else if (NCPU > 1 && reg_addr == ADDR_W'(emask_off(1))) reg_rdata = emask[1];
    else if (NCPU > 1 && reg_addr == ADDR_W'(lmask_off(1))) reg_rdata = lmask[1];
  end

  assign irq_sum0 = sum[0];
  assign irq_sum1 = sum[1];
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int GROUP  = 8,
  parameter int ADDR_W = 8,
  localparam int NGRP = LINES / GROUP
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LINES-1:0]      line_in,
  input logic                  reg_wr,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [LINES-1:0]      reg_wdata,
  input logic [LINES-1:0]      cause,
  input logic [1:0][LINES-1:0] emask,
  input logic [1:0][LINES-1:0] lmask,
  input logic [NGRP-1:0]       irq_sum0,
  input logic [NGRP-1:0]       irq_sum1
);
  logic             past_ok;
  logic [LINES-1:0] seen_prev;
  logic [LINES-1:0] rise_c;
  logic [LINES-1:0] keep_c;
  logic [NGRP-1:0]  exp0, exp1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      seen_prev <= '0;
    end else begin
      past_ok   <= 1'b1;
      seen_prev <= line_in;
    end
  end

  always_comb begin
    rise_c = line_in & ~seen_prev;
    keep_c = (reg_wr && reg_addr == ADDR_W'(OFF_CAUSE)) ? reg_wdata : '1;
    for (int g = 0; g < NGRP; g++) begin
      exp0[g] = |(((line_in & lmask[0]) | (cause & emask[0])) >> (g*GROUP) & {{(LINES-GROUP){1'b0}}, {GROUP{1'b1}}});
      exp1[g] = |(((line_in & lmask[1]) | (cause & emask[1])) >> (g*GROUP) & {{(LINES-GROUP){1'b0}}, {GROUP{1'b1}}});
    end
  end

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((cause & $past(rise_c)) == $past(rise_c)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((cause & $past(cause & keep_c)) == $past(cause & keep_c)));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((cause & $past(~keep_c & ~rise_c)) == '0));

  p_sum_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_sum0 == $past(exp0)));

  p_cpu1_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_sum1 == $past(exp1)));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.LINES(LINES), .GROUP(GROUP), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_in   (line_in),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cause     (cause),
  .emask     (emask),
  .lmask     (lmask),
  .irq_sum0  (irq_sum0),
  .irq_sum1  (irq_sum1)
);

// File: tb/sim_gpio_irq_agg.sv
module sim_gpio_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 32;
  localparam int NGRP  = 4;

  logic             clk;
  logic             rst_n;
  logic [LINES-1:0] line_in;
  logic             reg_wr;
  logic [7:0]       reg_addr;
  logic [LINES-1:0] reg_wdata;
  logic [LINES-1:0] reg_rdata;
  logic [NGRP-1:0]  irq_sum0, irq_sum1;

  int n_chk = 0;
  int n_bad = 0;

  gpio_irq_agg #(.LINES(LINES), .GROUP(8), .ADDR_W(8), .DUAL_CPU(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_sum0(irq_sum0), .irq_sum1(irq_sum1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0; line_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) step();
    check("R10 sum0 in reset", 32'(irq_sum0), 32'h0);
    rst_n = 1'b1;
    step();
    check("R10 sum0", 32'(irq_sum0), 32'h0);
    check("R10 sum1", 32'(irq_sum1), 32'h0);
    rd(8'h14, v); check("R10 cause", v, 32'h0);
    rd(8'h18, v); check("R10 emask0", v, 32'h0);
    rd(8'h1C, v); check("R10 lmask0", v, 32'h0);
    rd(8'h30, v); check("R10 emask1", v, 32'h0);
    rd(8'h34, v); check("R10 lmask1", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    step();
    wr(8'h18, 32'hA5A5_0F0F);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h18, v); check("R1 emask0 readback", v, 32'hA5A5_0F0F);
    rd(8'h1C, v); check("R1 lmask0 readback", v, 32'h1234_5678);
    rd(8'h10, v); check("R1 unmapped reads 0", v, 32'h0);
    wr(8'h18, 32'h0000_00F0);
    rd(8'h18, v); check("R1 mask replaced", v, 32'h0000_00F0);
    check("R1 no irq without cause", 32'(irq_sum0), 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    line_in[3] = 1'b1;
    step();
    rd(8'h14, v); check("R2 rise sets cause", v, 32'h0000_0008);
    line_in[3] = 1'b0;
    step(); step();
    rd(8'h14, v); check("R3 cause sticky after fall", v, 32'h0000_0008);
    line_in[20] = 1'b1;
    step();
    line_in[20] = 1'b0;
    rd(8'h14, v); check("R2 second edge", v, 32'h0010_0008);
    wr(8'h14, ~32'h0010_0000);
    rd(8'h14, v); check("R4 ack one bit keeps others", v, 32'h0000_0008);
    wr(8'h14, ~32'h0000_0008);
    rd(8'h14, v); check("R4 ack last bit", v, 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    line_in[5] = 1'b1;
    step();
    line_in[5] = 1'b0;
    step();
    rd(8'h14, v); check("R5 setup cause", v, 32'h0000_0020);
    line_in[5] = 1'b1;
    wr(8'h14, ~32'h0000_0020);
    rd(8'h14, v); check("R5 set wins over clear", v, 32'h0000_0020);
    line_in[5] = 1'b0;
    step();
    wr(8'h14, 32'h0);
    rd(8'h14, v); check("R4 clear all", v, 32'h0);
  endtask

  task automatic t_level();
    wr(8'h1C, 32'h0000_1000);
    line_in[12] = 1'b1;
    step();
    check("R6 level pending", 32'(irq_sum0), 32'h2);
    step();
    check("R6 level held", 32'(irq_sum0), 32'h2);
    line_in[12] = 1'b0;
    step();
    check("R6 level drops with line", 32'(irq_sum0), 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_edge_mask();
    line_in[25] = 1'b1;
    step();
    line_in[25] = 1'b0;
    step();
    check("R7 masked cause silent", 32'(irq_sum0), 32'h0);
    wr(8'h18, 32'h0200_0000);
    check("R8 one edge late after mask", 32'(irq_sum0), 32'h0);
    step();
    check("R7 unmasked cause raises", 32'(irq_sum0), 32'h8);
    check("R9 cpu1 unaffected", 32'(irq_sum1), 32'h0);
    wr(8'h14, 32'h0);
    step();
    check("R7 ack drops summary", 32'(irq_sum0), 32'h0);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_groups();
    wr(8'h18, 32'hFFFF_FFFF);
    line_in[7]  = 1'b1;
    line_in[31] = 1'b1;
    step();
    check("R8 registered latency", 32'(irq_sum0), 32'h0);
    step();
    check("R8 groups 0 and 3", 32'(irq_sum0), 32'h9);
    line_in[7]  = 1'b0;
    line_in[31] = 1'b0;
    line_in[8]  = 1'b1;
    step();
    line_in[8] = 1'b0;
    step();
    check("R8 group 1 joins", 32'(irq_sum0), 32'hB);
    wr(8'h14, 32'h0);
    step();
    check("R8 all clear", 32'(irq_sum0), 32'h0);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_cpu1();
    logic [31:0] v;
    wr(8'h34, 32'h0000_0200);
    wr(8'h30, 32'h0000_0001);
    rd(8'h34, v); check("R9 lmask1 readback", v, 32'h0000_0200);
    rd(8'h30, v); check("R9 emask1 readback", v, 32'h0000_0001);
    line_in[9] = 1'b1;
    step();
    check("R9 cpu1 level", 32'(irq_sum1), 32'h2);
    check("R9 cpu0 quiet", 32'(irq_sum0), 32'h0);
    line_in[9] = 1'b0;
    line_in[0] = 1'b1;
    step();
    line_in[0] = 1'b0;
    step();
    check("R9 cpu1 edge", 32'(irq_sum1), 32'h1);
    check("R9 cpu0 still quiet", 32'(irq_sum0), 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    step();
    check("R9 cpu1 cleared", 32'(irq_sum1), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_edge();
    t_setwins();
    t_level();
    t_edge_mask();
    t_groups();
    t_cpu1();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule